// File: doc/BRIEF.md
# Gated Call/Cancel Request Register

This block stores a bank of request flags of the sort that sit behind call buttons. Each lane has its own call and cancel input. A single active-high enable, shared by all lanes, gates both inputs. While the enable is low every flag keeps its value. While it is high, a call raises a flag and a cancel on its own drops it. Call takes priority over cancel, so the undefined both-active case of a cross-coupled set/reset cell cannot arise.

The register is fully synchronous. All updates happen on the rising edge of a free-running clock. A synchronous active-high reset clears every flag. Each output comes straight from a flop, so nothing passes combinationally from the inputs to the outputs. The lane count is a parameter, and the lanes do not interact.

Top module: `req_latch_bank`

## Requirements
- R1: On a rising clock edge with `rst` high, every bit of `req_q` becomes 0.
- R2: On a rising edge with `rst` low and `enable` low, `req_q` keeps its previous value, whatever `call` and `cancel` carry.
- R3: On a rising edge with `rst` low, `enable` high and `call[i]` high, `req_q[i]` becomes 1.
- R4: On a rising edge with `rst` low, `enable` high, `call[i]` low and `cancel[i]` high, `req_q[i]` becomes 0.
- R5: When `call[i]` and `cancel[i]` are both high with `enable` high, call wins and `req_q[i]` becomes 1.
- R6: On a rising edge with `rst` low, `enable` high and both `call[i]` and `cancel[i]` low, `req_q[i]` keeps its value.
- R7: Each lane's next value depends only on its own bit of `call`, its own bit of `cancel`, `enable` and its own stored bit.
- R8: `req_q` changes only at rising clock edges. Input activity between edges that is withdrawn before the next edge has no effect.
- R9: Reset takes precedence over `enable`, `call` and `cancel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Gate for call and cancel, shared by all lanes |
| call | input | NUM_REQ | Per-lane set request |
| cancel | input | NUM_REQ | Per-lane clear request |
| req_q | output | NUM_REQ | Stored request flags, driven from flops |

## Verification
Call and cancel on the same lane can arrive in the same cycle, and the priority rule must settle the result. The sweep drives every combination of `enable`, `call` and `cancel` over a three-lane bank, starting from a range of stored states. This means both-high patterns meet lanes that already hold 1 and lanes that hold 0. The bench judges the result against the arithmetic next value `enable ? (call | (q & ~cancel)) : q`, lane by lane. Reset is also asserted together with a full call pattern, to show that reset wins over a set.

// File: rtl/req_latch_pkg.sv
package req_latch_pkg;

   // Per-lane action chosen from the gated inputs
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_SET   = 2'd1,
      ACT_CLEAR = 2'd2
   } req_act_e;

   // Call outranks cancel; nothing happens while the gate is closed
   function automatic req_act_e pick_action(input logic gate,
                                            input logic set_in,
                                            input logic clr_in);
      req_act_e act;
      act = ACT_HOLD;
      if (gate) begin
         if (set_in)      act = ACT_SET;
         else if (clr_in) act = ACT_CLEAR;
      end
      return act;
   endfunction

endpackage

// File: rtl/req_latch_decode.sv
module req_latch_decode
   import req_latch_pkg::*;
#(
   parameter int NUM_REQ = 4
) (
   input  logic               enable,
   input  logic [NUM_REQ-1:0] call,
   input  logic [NUM_REQ-1:0] cancel,
   output req_act_e           act [NUM_REQ]
);

   genvar g;
   generate
      for (g = 0; g < NUM_REQ; g++) begin : g_lane
         assign act[g] = pick_action(enable, call[g], cancel[g]);
      end
   endgenerate

endmodule

// File: rtl/req_latch_store.sv
module req_latch_store
   import req_latch_pkg::*;
#(
   parameter int NUM_REQ = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  req_act_e           act [NUM_REQ],
   output logic [NUM_REQ-1:0] q
);

   genvar g;
   generate
      for (g = 0; g < NUM_REQ; g++) begin : g_bit
         logic nxt;
         always_comb begin
            unique case (act[g])
               ACT_SET:   nxt = 1'b1;
               ACT_CLEAR: nxt = 1'b0;
               default:   nxt = q[g];
            endcase
         end
         always_ff @(posedge clk) begin
            if (rst) q[g] <= 1'b0;
            else     q[g] <= nxt;
         end
      end
   endgenerate

endmodule

// File: rtl/req_latch_bank.sv
module req_latch_bank
   import req_latch_pkg::*;
#(
   parameter int NUM_REQ = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               enable,
   input  logic [NUM_REQ-1:0] call,
   input  logic [NUM_REQ-1:0] cancel,
   output logic [NUM_REQ-1:0] req_q
);

   localparam int LaneCount = NUM_REQ;

   generate
      if (LaneCount < 1) begin : g_bad_cfg
         $error("req_latch_bank: NUM_REQ must be at least 1");
      end
   endgenerate

   req_act_e lane_act [LaneCount];

   req_latch_decode #(.NUM_REQ(LaneCount)) u_decode (
      .enable (enable),
      .call   (call),
      .cancel (cancel),
      .act    (lane_act)
   );

   req_latch_store #(.NUM_REQ(LaneCount)) u_store (
      .clk (clk),
      .rst (rst),
      .act (lane_act),
      .q   (req_q)
   );

endmodule

// File: rtl/req_latch_bank_chk.sv
module req_latch_bank_chk #(
   parameter int NUM_REQ = 4
) (
   input logic               clk,
   input logic               rst,
   input logic               enable,
   input logic [NUM_REQ-1:0] call,
   input logic [NUM_REQ-1:0] cancel,
   input logic [NUM_REQ-1:0] req_q
);

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (req_q == '0)); // R1

   AST_RESET_BEATS_CALL: assert property (@(posedge clk)
      (rst && enable && (call != '0)) |=> (req_q == '0)); // R9

   AST_GATE_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !enable |=> $stable(req_q)); // R2

   AST_CALL_SETS: assert property (@(posedge clk) disable iff (rst)
      enable |=> ((req_q & $past(call)) == $past(call))); // R3

   AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (rst)
      enable |=> ((req_q & $past(cancel & ~call)) == '0)); // R4

   AST_CALL_OUTRANKS: assert property (@(posedge clk) disable iff (rst)
      enable |=> ((req_q & $past(cancel & call)) == $past(cancel & call))); // R5

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      enable |=> (((req_q ^ $past(req_q)) & $past(~call & ~cancel)) == '0)); // R6

endmodule

bind req_latch_bank req_latch_bank_chk #(.NUM_REQ(NUM_REQ)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .enable (enable),
   .call   (call),
   .cancel (cancel),
   .req_q  (req_q)
);

// File: tb/req_latch_bank_bench.sv
module req_latch_bank_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 3;
   localparam int PATS       = 1 << N;

   logic         clk = 1'b0;
   logic         rst;
   logic         enable;
   logic [N-1:0] call;
   logic [N-1:0] cancel;
   logic [N-1:0] req_q;
   logic [N-1:0] model;

   int n_cmp  = 0;
   int n_bad  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   req_latch_bank #(.NUM_REQ(N)) u_req_latch_bank (
      .clk    (clk),
      .rst    (rst),
      .enable (enable),
      .call   (call),
      .cancel (cancel),
      .req_q  (req_q)
   );

   task automatic cmp_bit(input string tag, input logic act, input logic exp, input int lane);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s lane %0d: got %b expected %b", tag, lane, act, exp);
      end
   endtask

   task automatic cmp_vec(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   // Called at a falling edge: drive, let one rising edge pass, check at next falling edge
   task automatic step(input logic e, input logic [N-1:0] c, input logic [N-1:0] x);
      logic [N-1:0] nxt;
      enable = e; call = c; cancel = x;
      nxt = e ? (c | (model & ~x)) : model;
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
         if (!e)                     cmp_bit("R2 gate closed", req_q[i], nxt[i], i);
         else if (c[i] && x[i])      cmp_bit("R5 call outranks cancel", req_q[i], nxt[i], i);
         else if (c[i])              cmp_bit("R3 call sets", req_q[i], nxt[i], i);
         else if (x[i])              cmp_bit("R4 cancel clears", req_q[i], nxt[i], i);
         else                        cmp_bit("R6 idle holds", req_q[i], nxt[i], i);
      end
      cmp_vec("R7 lanes independent", req_q, nxt);
      model = nxt;
   endtask

   initial begin
      rst = 1'b1; enable = 1'b0; call = '0; cancel = '0;
      model = '0;
      repeat (2) @(negedge clk);
      cmp_vec("R1 reset state", req_q, '0);

      // R9: reset while a full gated call is presented
      enable = 1'b1; call = '1; cancel = '0;
      @(negedge clk);
      cmp_vec("R9 reset beats call", req_q, '0);
      rst = 1'b0;

      // Exhaustive sweep, two passes in opposite orders
      for (int pass = 0; pass < 2; pass++) begin
         for (int k = 0; k < 2*PATS*PATS; k++) begin
            int idx;
            idx = (pass == 0) ? k : (2*PATS*PATS - 1 - k);
            step(idx[0], N'(idx >> 1), N'(idx >> (1 + N)));
         end
      end

      // R8: a pulse withdrawn before the rising edge leaves no trace
      step(1'b1, 3'b101, 3'b000);
      enable = 1'b0; call = '0; cancel = '0;
      #(CLK_PERIOD/4);
      enable = 1'b1; cancel = '1;
      #(CLK_PERIOD/8);
      cmp_vec("R8 no combinational path", req_q, model);
      enable = 1'b0; cancel = '0;
      @(negedge clk);
      cmp_vec("R8 withdrawn pulse ignored", req_q, model);

      // R1 again from a non-zero state
      step(1'b1, '1, '0);
      rst = 1'b1;
      @(negedge clk);
      cmp_vec("R1 reset from set state", req_q, '0);
      rst = 1'b0;

      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule